// File: doc/BRIEF.md
# Iterative Multiply/Divide Unit

This unit carries out 16x16 multiplication and 32/16 division for an integer execution pipeline, both unsigned and signed. A one-cycle `start` pulse launches an operation on a 32-bit destination value and a 16-bit source operand. A one-cycle `done` pulse returns a 32-bit result together with negative, zero, overflow and carry flags. Multiplication takes a fixed two cycles. Division runs a shift-and-subtract loop that produces one quotient bit per cycle, so its latency depends on the data.

Division works on operand magnitudes. The divisor magnitude is first doubled until doubling once more would pass the dividend. The loop then walks the divisor back down to its original value and builds the quotient on the way. Signs are applied at the end. The quotient and the remainder are packed into one word. A zero divisor is replaced by one so that the loop always ends, and the event is flagged on a separate output.

Top module: `muldiv_iter`

## Requirements
- R1: Unsigned multiply (`is_div`=0, `is_signed`=0) returns the 32-bit product of `dst_val[15:0]` and `src_val`, with both operands zero-extended.
- R2: Signed multiply (`is_signed`=1) sign-extends both 16-bit operands and returns the 32-bit two's-complement product.
- R3: After a multiply, `flag_n` equals result bit 31 and `flag_z` is set exactly when the 32-bit result is zero. `flag_v` and `flag_c` are 0.
- R4: An unsigned divide returns the quotient `dst_val / src_val` in result bits 15:0 and the remainder in bits 31:16.
- R5: A signed divide divides the magnitudes. The quotient is negated when exactly one operand is negative, and the remainder carries the sign of the dividend.
- R6: After a divide that does not overflow, `flag_n` equals result bit 15 and `flag_z` is set exactly when result bits 15:0 are zero. `flag_v` and `flag_c` are 0.
- R7: If the quotient does not fit in 16 bits (0..65535 unsigned, -32768..32767 signed), the result equals `dst_val`, `flag_v` is 1, and `flag_n`, `flag_z` and `flag_c` are 0.
- R8: A zero `src_val` on a divide is treated as a divisor of 1, and `div_zero` is high in the same cycle as `done` and in no other cycle.
- R9: A `start` presented while an operation is in progress is ignored. Each accepted operation produces exactly one single-cycle `done` pulse.
- R10: For a multiply, `done` is high in the second cycle after the cycle in which `start` was accepted. A divide finishes within 70 cycles.
- R11: After reset, `done`, `div_zero`, `result` and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch an operation (accepted only when idle) |
| is_div | input | 1 | 1 = divide, 0 = multiply |
| is_signed | input | 1 | 1 = two's-complement operands |
| dst_val | input | 32 | Destination value (dividend, or multiplicand in bits 15:0) |
| src_val | input | 16 | Source operand (divisor or multiplier) |
| done | output | 1 | One-cycle completion pulse |
| result | output | 32 | Product, or {remainder, quotient}, or `dst_val` on overflow |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag |
| flag_c | output | 1 | Carry flag (always 0) |
| div_zero | output | 1 | Divide by zero, pulsed together with `done` |

## Verification
The embedded assertions check on every cycle that `done` lasts one cycle, that `div_zero` only appears with `done`, that the carry flag stays clear, that overflow excludes the N and Z flags, and that multiply latency is exact. Inside the divider they check that the shifted divisor never drops below its original value and that the partial remainder always stays under twice the current divisor. The bench alone can show the arithmetic values: products, quotients, remainders and their signs, the overflow boundaries at 32767, 32768 and 65535, the zero-divisor substitution, and that a second `start` during a busy operation leaves no trace.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

    localparam int SRC_W = 16;
    localparam int DST_W = 32;

    typedef enum logic [1:0] {OP_IDLE, OP_MUL, OP_DIV} op_state_t;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } ccr_t;

    typedef struct packed {
        logic sgn;
        logic neg_quo;
        logic neg_rem;
        logic by_zero;
    } div_ctx_t;

    function automatic logic [DST_W-1:0] mag_dst(input logic [DST_W-1:0] x, input logic sgn);
        return (sgn && x[DST_W-1]) ? (~x + 1'b1) : x;
    endfunction

    function automatic logic [SRC_W-1:0] mag_src(input logic [SRC_W-1:0] x, input logic sgn);
        return (sgn && x[SRC_W-1]) ? (~x + 1'b1) : x;
    endfunction

    // Does a quotient magnitude fit a SRC_W-bit result of the selected kind?
    function automatic logic quo_fits(input logic [DST_W-1:0] q, input logic sgn, input logic neg);
        logic [DST_W-1:0] lim;
        if (!sgn)
            lim = (DST_W'(1) << SRC_W) - 1'b1;
        else if (neg)
            lim = DST_W'(1) << (SRC_W - 1);
        else
            lim = (DST_W'(1) << (SRC_W - 1)) - 1'b1;
        return q <= lim;
    endfunction

endpackage

// File: rtl/mul_unit.sv
module mul_unit
    import muldiv_pkg::*;
(
    input  logic [SRC_W-1:0] a,
    input  logic [SRC_W-1:0] b,
    input  logic             sgn,
    output logic [DST_W-1:0] prod
);
    localparam int EXT_W = SRC_W + 1;

    logic signed [EXT_W-1:0]   ea;
    logic signed [EXT_W-1:0]   eb;
    logic signed [2*EXT_W-1:0] full;

    always_comb begin
        ea   = {sgn & a[SRC_W-1], a};
        eb   = {sgn & b[SRC_W-1], b};
        full = ea * eb;
        prod = full[DST_W-1:0];
    end
endmodule

// File: rtl/div_core.sv
module div_core
    import muldiv_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    input  logic [DST_W-1:0] dividend,
    input  logic [SRC_W-1:0] divisor,
    output logic             fin,
    output logic [DST_W-1:0] quo,
    output logic [DST_W-1:0] rem
);
    typedef enum logic [1:0] {D_IDLE, D_ALIGN, D_STEP} dstate_t;

    dstate_t          st_q;
    logic [DST_W-1:0] dvs_q;
    logic [DST_W-1:0] orig_q;
    logic             ge;

    assign ge = rem >= dvs_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= D_IDLE;
            dvs_q  <= '0;
            orig_q <= '0;
            quo    <= '0;
            rem    <= '0;
            fin    <= 1'b0;
        end else begin
            fin <= 1'b0;
            case (st_q)
                D_IDLE: if (go) begin
                    rem    <= dividend;
                    dvs_q  <= DST_W'(divisor);
                    orig_q <= DST_W'(divisor);
                    quo    <= '0;
                    st_q   <= D_ALIGN;
                end
                D_ALIGN: begin
                    if (dvs_q <= (rem >> 1)) dvs_q <= dvs_q << 1;
                    else                     st_q  <= D_STEP;
                end
                D_STEP: begin
                    quo <= {quo[DST_W-2:0], ge};
                    if (ge) rem <= rem - dvs_q;
                    if (dvs_q == orig_q) begin
                        fin  <= 1'b1;
                        st_q <= D_IDLE;
                    end else begin
                        dvs_q <= dvs_q >> 1;
                    end
                end
                default: st_q <= D_IDLE;
            endcase
        end
    end

    // R4: the walked divisor never falls below the original divisor
    p_dvs_floor_r4: assert property (@(posedge clk) disable iff (rst)
        (st_q == D_STEP) |-> (dvs_q >= orig_q));

    // R4: partial remainder stays under twice the current divisor in each step
    p_rem_bound_r4: assert property (@(posedge clk) disable iff (rst)
        (st_q == D_STEP) |-> ({1'b0, rem} < {dvs_q, 1'b0}));
endmodule

// File: rtl/muldiv_iter.sv
module muldiv_iter
    import muldiv_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic        is_div,
    input  logic        is_signed,
    input  logic [31:0] dst_val,
    input  logic [15:0] src_val,
    output logic        done,
    output logic [31:0] result,
    output logic        flag_n,
    output logic        flag_z,
    output logic        flag_v,
    output logic        flag_c,
    output logic        div_zero
);
    op_state_t        state_q;
    logic             sgn_q;
    logic [SRC_W-1:0] opa_q;
    logic [SRC_W-1:0] opb_q;
    logic [DST_W-1:0] dst_q;
    div_ctx_t         ctx_q;
    ccr_t             ccr_q;

    logic             accept;
    logic             div_go;
    logic [SRC_W-1:0] dvs_mag;
    logic [DST_W-1:0] dvd_mag;
    logic             div_fin;
    logic [DST_W-1:0] quo;
    logic [DST_W-1:0] rem;
    logic [DST_W-1:0] prod;
    logic             fits;
    logic [SRC_W-1:0] q16;
    logic [SRC_W-1:0] r16;

    assign accept  = start && (state_q == OP_IDLE);
    assign div_go  = accept && is_div;
    assign dvs_mag = (src_val == '0) ? SRC_W'(1) : mag_src(src_val, is_signed);
    assign dvd_mag = mag_dst(dst_val, is_signed);

    div_core u_div (
        .clk      (clk),
        .rst      (rst),
        .go       (div_go),
        .dividend (dvd_mag),
        .divisor  (dvs_mag),
        .fin      (div_fin),
        .quo      (quo),
        .rem      (rem)
    );

    mul_unit u_mul (
        .a    (opa_q),
        .b    (opb_q),
        .sgn  (sgn_q),
        .prod (prod)
    );

    always_comb begin
        fits = quo_fits(quo, ctx_q.sgn, ctx_q.neg_quo);
        q16  = ctx_q.neg_quo ? (~quo[SRC_W-1:0] + 1'b1) : quo[SRC_W-1:0];
        r16  = ctx_q.neg_rem ? (~rem[SRC_W-1:0] + 1'b1) : rem[SRC_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= OP_IDLE;
            sgn_q    <= 1'b0;
            opa_q    <= '0;
            opb_q    <= '0;
            dst_q    <= '0;
            ctx_q    <= '0;
            ccr_q    <= '0;
            result   <= '0;
            done     <= 1'b0;
            div_zero <= 1'b0;
        end else begin
            done     <= 1'b0;
            div_zero <= 1'b0;
            case (state_q)
                OP_IDLE: if (accept) begin
                    sgn_q         <= is_signed;
                    opa_q         <= dst_val[SRC_W-1:0];
                    opb_q         <= src_val;
                    dst_q         <= dst_val;
                    ctx_q.sgn     <= is_signed;
                    ctx_q.neg_quo <= is_signed && (dst_val[DST_W-1] ^ src_val[SRC_W-1]);
                    ctx_q.neg_rem <= is_signed && dst_val[DST_W-1];
                    ctx_q.by_zero <= (src_val == '0);
                    state_q       <= is_div ? OP_DIV : OP_MUL;
                end
                OP_MUL: begin
                    result  <= prod;
                    ccr_q   <= '{n: prod[DST_W-1], z: (prod == '0), v: 1'b0, c: 1'b0};
                    done    <= 1'b1;
                    state_q <= OP_IDLE;
                end
                OP_DIV: if (div_fin) begin
                    if (fits) begin
                        result <= {r16, q16};
                        ccr_q  <= '{n: q16[SRC_W-1], z: (q16 == '0), v: 1'b0, c: 1'b0};
                    end else begin
                        result <= dst_q;
                        ccr_q  <= '{n: 1'b0, z: 1'b0, v: 1'b1, c: 1'b0};
                    end
                    done     <= 1'b1;
                    div_zero <= ctx_q.by_zero;
                    state_q  <= OP_IDLE;
                end
                default: state_q <= OP_IDLE;
            endcase
        end
    end

    assign flag_n = ccr_q.n;
    assign flag_z = ccr_q.z;
    assign flag_v = ccr_q.v;
    assign flag_c = ccr_q.c;

    // R9: completion is a single-cycle pulse
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8: divide-by-zero never appears without completion
    p_divzero_with_done_r8: assert property (@(posedge clk) disable iff (rst)
        div_zero |-> done);

    // R3 / R6: carry is clear whenever a result is delivered
    p_carry_clear_r3: assert property (@(posedge clk) disable iff (rst)
        done |-> !flag_c);

    // R7: overflow excludes the negative and zero flags
    p_no_overflow_nz_r7: assert property (@(posedge clk) disable iff (rst)
        (done && flag_v) |-> (!flag_n && !flag_z));

    // R10: multiply completes exactly two cycles after acceptance
    p_mul_latency_r10: assert property (@(posedge clk) disable iff (rst)
        (start && (state_q == OP_IDLE) && !is_div) |=> ##1 done);
endmodule

// File: tb/sim_muldiv_iter.sv
module sim_muldiv_iter;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic        is_div;
    logic        is_signed;
    logic [31:0] dst_val;
    logic [15:0] src_val;
    logic        done;
    logic [31:0] result;
    logic        flag_n, flag_z, flag_v, flag_c;
    logic        div_zero;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    muldiv_iter u0 (
        .clk(clk), .rst(rst), .start(start), .is_div(is_div), .is_signed(is_signed),
        .dst_val(dst_val), .src_val(src_val), .done(done), .result(result),
        .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c),
        .div_zero(div_zero)
    );

    task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // expected = {result, n, z, v, c, div_zero}
    function automatic logic [36:0] model(input logic dv, input logic sg,
                                          input logic [31:0] a, input logic [15:0] b);
        logic [31:0] p, ma, q, r;
        logic [15:0] mb, qs, rs;
        logic nq, fit;
        if (!dv) begin
            p = $signed({{16{sg & a[15]}}, a[15:0]}) * $signed({{16{sg & b[15]}}, b});
            return {p, p[31], p == 0, 1'b0, 1'b0, 1'b0};
        end
        ma = (sg && a[31]) ? -a : a;
        mb = (sg && b[15]) ? -b : b;
        if (b == 0) mb = 16'd1;
        q  = ma / {16'd0, mb};
        r  = ma % {16'd0, mb};
        nq = sg && (a[31] ^ b[15]);
        fit = !sg ? (q <= 32'd65535) : (nq ? (q <= 32'd32768) : (q <= 32'd32767));
        if (!fit) return {a, 1'b0, 1'b0, 1'b1, 1'b0, b == 0};
        qs = nq ? -q[15:0] : q[15:0];
        rs = (sg && a[31]) ? -r[15:0] : r[15:0];
        return {rs, qs, qs[15], qs == 0, 1'b0, 1'b0, b == 0};
    endfunction

    // Launch one op; optionally fire a second start while busy; wait and check.
    task automatic run_op(input string req, input logic dv, input logic sg,
                          input logic [31:0] a, input logic [15:0] b, input logic poke);
        logic [36:0] exp;
        int lat;
        exp = model(dv, sg, a, b);
        @(negedge clk);
        is_div = dv; is_signed = sg; dst_val = a; src_val = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        if (poke) begin
            is_div = ~dv; is_signed = ~sg; dst_val = ~a; src_val = b ^ 16'h1234; start = 1'b1;
        end
        while (!done && lat < 100) begin
            @(negedge clk);
            start = 1'b0;
            lat++;
        end
        if (!done) begin
            check(req, "no done", 0, 1);
            return;
        end
        check(req, "result", {32'd0, result}, {32'd0, exp[36:5]});
        check(req, "flags nzvc", {flag_n, flag_z, flag_v, flag_c}, exp[4:1]);
        check("R8", "div_zero", div_zero, exp[0]);
        if (!dv) check("R10", "mul latency", lat, 2);
        else     check("R10", "div latency bound", lat <= 70, 1);
        @(negedge clk);
        check("R9", "done one cycle", {done, div_zero}, 0);
        if (poke) begin
            for (int i = 0; i < 80; i++) begin
                if (done) break;
                @(negedge clk);
            end
            check("R9", "busy start ignored", done, 0);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] ra;
        logic [15:0] rb;
        logic rd, rs;
        void'($urandom(32'd20240611));
        rst = 1'b1; start = 1'b0; is_div = 1'b0; is_signed = 1'b0;
        dst_val = '0; src_val = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R11", "reset outputs", {result, done, div_zero, flag_n, flag_z, flag_v, flag_c}, 0);
        rst = 1'b0;

        run_op("R1", 0, 0, 32'h0000FFFF, 16'hFFFF, 0);
        run_op("R2", 0, 1, 32'h0000FFFF, 16'hFFFF, 0);
        run_op("R2", 0, 1, 32'h1234FFFF, 16'd5, 0);
        run_op("R3", 0, 0, 32'hABCD0000, 16'h7777, 0);
        run_op("R4", 1, 0, 32'd100, 16'd7, 0);
        run_op("R4", 1, 0, 32'd3, 16'd9, 0);
        run_op("R5", 1, 1, -32'sd100, 16'd7, 0);
        run_op("R5", 1, 1, 32'd100, -16'sd7, 0);
        run_op("R5", 1, 1, -32'sd100, -16'sd7, 0);
        run_op("R6", 1, 0, 32'd0, 16'd3, 0);
        run_op("R7", 1, 0, 32'h00010000, 16'd1, 0);
        run_op("R7", 1, 0, 32'h0000FFFF, 16'd1, 0);
        run_op("R7", 1, 1, 32'hFFFF8000, 16'd1, 0);
        run_op("R7", 1, 1, 32'h00008000, 16'd1, 0);
        run_op("R7", 1, 1, 32'h00007FFF, 16'd1, 0);
        run_op("R7", 1, 1, 32'h80000000, 16'hFFFF, 0);
        run_op("R8", 1, 0, 32'd5, 16'd0, 0);
        run_op("R8", 1, 1, 32'hFFFFFFFB, 16'd0, 0);
        run_op("R9", 0, 0, 32'd300, 16'd300, 1);
        run_op("R9", 1, 0, 32'd123456, 16'd1000, 1);

        for (int k = 0; k < 400; k++) begin
            rd = $urandom_range(0, 1);
            rs = $urandom_range(0, 1);
            ra = $urandom;
            rb = 16'($urandom);
            if (k % 3 == 0) ra = {{16{ra[31]}}, ra[15:0]} >>> $urandom_range(0, 8);
            if (k % 17 == 0) rb = 16'd0;
            run_op(rd ? (rs ? "R5" : "R4") : (rs ? "R2" : "R1"), rd, rs, ra, rb, k % 11 == 0);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule